// File: doc/BRIEF.md
# Program/Data Bus Exchange Unit

This unit joins a 24-bit program-memory data bus to a 16-bit data-memory data bus. It keeps an 8-bit side register that holds the low byte of 24-bit memory words. When the processor reads 16-bit data from program memory, the unit splits the word. The upper 16 bits go to the destination register, and the low byte is captured into the side register at the next clock edge. When the processor writes 16-bit data to program memory, the unit rebuilds a 24-bit word. The register source supplies the upper 16 bits. The low byte comes from the side register, or is driven to zero for write classes that do not use it.

Software can also move values into and out of the side register through the register-file port. A load keeps only the low byte of the 16-bit source. A read returns the byte zero-extended to 16 bits.

Some accesses must not touch the side register:

- Instruction fetches.
- Dual reads that route the upper 16 bits of the program-memory word straight to the Y-operand path.

Each clock, a small selector picks one update source for the side register:

- HOLD: nothing is loaded.
- FROM_PM: a qualifying program-memory data read is in progress.
- FROM_REG: an explicit load is requested.

FROM_PM takes priority over FROM_REG.

Top module: `pm_dm_bus_exchange`

## Requirements
- R1: While `rst` is high at a rising clock edge, the side register becomes 0x00. After that edge, `xr_read_val` reads 0x0000.
- R2: While `pm_data_rd` is 1 and `pm_fetch` is 0, `rd_to_reg` equals `pm_rd_word[23:8]` in the same cycle; otherwise `rd_to_reg` is 0x0000.
- R3: A data read (`pm_data_rd`=1, `pm_fetch`=0, `pm_y_route`=0) loads `pm_rd_word[7:0]` into the side register at the next rising edge.
- R4: A cycle with `pm_fetch`=1 never loads the side register from the program-memory bus. This holds even when `pm_data_rd` is 1 in the same cycle.
- R5: While `pm_y_route` is 1, `y_operand` equals `pm_rd_word[23:8]`; otherwise `y_operand` is 0x0000. A cycle with `pm_y_route`=1 never loads the side register from the bus.
- R6: While `pm_wr_en` and `wr_uses_xr` are both 1, `pm_wr_word` equals {`reg_src`, side register}.
- R7: While `pm_wr_en` is 1 and `wr_uses_xr` is 0, `pm_wr_word` equals {`reg_src`, 8'h00}. While `pm_wr_en` is 0, `pm_wr_word` is 0.
- R8: With `xr_load`=1 and no qualifying data read, the side register takes `reg_src[7:0]` at the next edge. Bits 15:8 of `reg_src` are discarded.
- R9: `xr_read_val` is {8'h00, side register}: bits 15:8 are always zero.
- R10: If an explicit load and a qualifying data read occur in the same cycle, the side register takes `pm_rd_word[7:0]`.
- R11: In a cycle that updates the side register, `xr_read_val` and `pm_wr_word[7:0]` still show the old value. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pm_rd_word | input | 24 | Word on the program-memory read bus |
| pm_data_rd | input | 1 | Program-memory access is a data read into a register |
| pm_fetch | input | 1 | Program-memory access is an instruction fetch |
| pm_y_route | input | 1 | Dual read that routes the upper 16 bits to the Y-operand path |
| y_operand | output | 16 | Upper 16 bits of the read word on the Y-operand path |
| rd_to_reg | output | 16 | Upper 16 bits of a data read, toward the destination register |
| reg_src | input | 16 | Value from the register-file read port |
| xr_load | input | 1 | Explicit move of `reg_src` into the side register |
| xr_read_val | output | 16 | Side register, zero-extended, as a register source |
| pm_wr_en | input | 1 | Program-memory data write this cycle |
| wr_uses_xr | input | 1 | The write instruction class merges the side register |
| pm_wr_word | output | 24 | Rebuilt word for the program-memory write bus |

## Verification
The bench goes after four corner cases:

- A fetch that overlaps a data-read strobe. A selector that ignored the fetch flag would overwrite the side register with a byte from an instruction.
- A Y-route dual read. A design that let the bypass fall through to the exchange path would corrupt the side register.
- An explicit load in the same cycle as a data read. Inverting the priority would leave the register holding the register-file byte.
- Writes with and without the merge flag. A merge that ignored the flag would leak a stale byte into words that must end in zero.

Reads taken in an update cycle must show the old value. A design that forwarded the incoming byte would fail these checks.

// File: rtl/pm_dm_bus_exchange_pkg.sv
package pm_dm_bus_exchange_pkg;

    typedef enum logic [1:0] {
        XR_HOLD     = 2'd0,
        XR_FROM_PM  = 2'd1,
        XR_FROM_REG = 2'd2
    } xr_src_e;

endpackage

// File: rtl/pm_dm_xr_select.sv
module pm_dm_xr_select
    import pm_dm_bus_exchange_pkg::*;
(
    input  logic    data_rd,
    input  logic    fetch,
    input  logic    y_route,
    input  logic    load_req,
    output xr_src_e src_sel
);
    logic bus_qual;

    always_comb begin
        bus_qual = data_rd & ~fetch & ~y_route;
        if (bus_qual) begin
            src_sel = XR_FROM_PM;
        end else if (load_req) begin
            src_sel = XR_FROM_REG;
        end else begin
            src_sel = XR_HOLD;
        end
    end
endmodule

// File: rtl/pm_dm_xr_reg.sv
module pm_dm_xr_reg
    import pm_dm_bus_exchange_pkg::*;
#(
    parameter int XW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  xr_src_e       src_sel,
    input  logic [XW-1:0] bus_byte,
    input  logic [XW-1:0] reg_byte,
    output logic [XW-1:0] xr_q
);
    logic [XW-1:0] xr_d;

    always_comb begin
        unique case (src_sel)
            XR_FROM_PM:  xr_d = bus_byte;
            XR_FROM_REG: xr_d = reg_byte;
            default:     xr_d = xr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xr_q <= '0;
        end else begin
            xr_q <= xr_d;
        end
    end
endmodule

// File: rtl/pm_dm_word_merge.sv
module pm_dm_word_merge #(
    parameter int PM_W = 24,
    parameter int DM_W = 16
) (
    input  logic                 wr_en,
    input  logic                 uses_xr,
    input  logic [DM_W-1:0]      src,
    input  logic [PM_W-DM_W-1:0] xr,
    output logic [PM_W-1:0]      word
);
    localparam int XW = PM_W - DM_W;

    logic [XW-1:0] low_byte;

    always_comb begin
        low_byte = uses_xr ? xr : '0;
        word     = wr_en ? {src, low_byte} : '0;
    end
endmodule

// File: rtl/pm_dm_bus_exchange.sv
module pm_dm_bus_exchange
    import pm_dm_bus_exchange_pkg::*;
#(
    parameter int PM_W = 24,
    parameter int DM_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PM_W-1:0] pm_rd_word,
    input  logic            pm_data_rd,
    input  logic            pm_fetch,
    input  logic            pm_y_route,
    output logic [DM_W-1:0] y_operand,
    output logic [DM_W-1:0] rd_to_reg,
    input  logic [DM_W-1:0] reg_src,
    input  logic            xr_load,
    output logic [DM_W-1:0] xr_read_val,
    input  logic            pm_wr_en,
    input  logic            wr_uses_xr,
    output logic [PM_W-1:0] pm_wr_word
);
    localparam int XW = PM_W - DM_W;

    xr_src_e       src_sel;
    logic [XW-1:0] xr_q;
    logic [DM_W-1:0] upper_half;

    pm_dm_xr_select u_sel (
        .data_rd  (pm_data_rd),
        .fetch    (pm_fetch),
        .y_route  (pm_y_route),
        .load_req (xr_load),
        .src_sel  (src_sel)
    );

    pm_dm_xr_reg #(.XW(XW)) u_xr (
        .clk      (clk),
        .rst      (rst),
        .src_sel  (src_sel),
        .bus_byte (pm_rd_word[XW-1:0]),
        .reg_byte (reg_src[XW-1:0]),
        .xr_q     (xr_q)
    );

    pm_dm_word_merge #(.PM_W(PM_W), .DM_W(DM_W)) u_merge (
        .wr_en   (pm_wr_en),
        .uses_xr (wr_uses_xr),
        .src     (reg_src),
        .xr      (xr_q),
        .word    (pm_wr_word)
    );

    always_comb begin
        upper_half  = pm_rd_word[PM_W-1:XW];
        rd_to_reg   = (pm_data_rd && !pm_fetch) ? upper_half : '0;
        y_operand   = pm_y_route ? upper_half : '0;
        xr_read_val = {{(DM_W-XW){1'b0}}, xr_q};
    end
endmodule

// File: rtl/pm_dm_bus_exchange_chk.sv
module pm_dm_bus_exchange_chk #(
    parameter int PM_W = 24,
    parameter int DM_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [PM_W-1:0] pm_rd_word,
    input logic            pm_data_rd,
    input logic            pm_fetch,
    input logic            pm_y_route,
    input logic [DM_W-1:0] reg_src,
    input logic            xr_load,
    input logic [DM_W-1:0] xr_read_val,
    input logic            pm_wr_en,
    input logic            wr_uses_xr,
    input logic [PM_W-1:0] pm_wr_word
);
    localparam int XW = PM_W - DM_W;

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (xr_read_val == '0)); // R1

    AST_PM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (pm_data_rd && !pm_fetch && !pm_y_route) |=>
            (xr_read_val[XW-1:0] == $past(pm_rd_word[XW-1:0]))); // R3

    AST_NO_BUS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!xr_load && (pm_fetch || pm_y_route || !pm_data_rd)) |=>
            $stable(xr_read_val)); // R4

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (xr_load && !(pm_data_rd && !pm_fetch && !pm_y_route)) |=>
            (xr_read_val[XW-1:0] == $past(reg_src[XW-1:0]))); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        xr_read_val[DM_W-1:XW] == '0); // R9

    AST_WR_MERGE: assert property (@(posedge clk) disable iff (rst)
        (pm_wr_en && wr_uses_xr) |->
            (pm_wr_word == {reg_src, xr_read_val[XW-1:0]})); // R6

    AST_WR_NOXR: assert property (@(posedge clk) disable iff (rst)
        (pm_wr_en && !wr_uses_xr) |-> (pm_wr_word == {reg_src, {XW{1'b0}}})); // R7
endmodule

bind pm_dm_bus_exchange pm_dm_bus_exchange_chk #(.PM_W(PM_W), .DM_W(DM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pm_rd_word  (pm_rd_word),
    .pm_data_rd  (pm_data_rd),
    .pm_fetch    (pm_fetch),
    .pm_y_route  (pm_y_route),
    .reg_src     (reg_src),
    .xr_load     (xr_load),
    .xr_read_val (xr_read_val),
    .pm_wr_en    (pm_wr_en),
    .wr_uses_xr  (wr_uses_xr),
    .pm_wr_word  (pm_wr_word)
);

// File: tb/pm_dm_bus_exchange_bench.sv
module pm_dm_bus_exchange_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] pm_rd_word;
    logic        pm_data_rd, pm_fetch, pm_y_route;
    logic [15:0] y_operand, rd_to_reg, reg_src, xr_read_val;
    logic        xr_load, pm_wr_en, wr_uses_xr;
    logic [23:0] pm_wr_word;

    int vectors = 0;
    int miscompares = 0;
    int model_xr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pm_dm_bus_exchange u_pm_dm_bus_exchange (
        .clk(clk), .rst(rst), .pm_rd_word(pm_rd_word), .pm_data_rd(pm_data_rd),
        .pm_fetch(pm_fetch), .pm_y_route(pm_y_route), .y_operand(y_operand),
        .rd_to_reg(rd_to_reg), .reg_src(reg_src), .xr_load(xr_load),
        .xr_read_val(xr_read_val), .pm_wr_en(pm_wr_en), .wr_uses_xr(wr_uses_xr),
        .pm_wr_word(pm_wr_word)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare outputs against the model, then advance the model over the edge
    task automatic step(input bit r, input int word, input bit drd, input bit fch,
                        input bit yr, input int src, input bit ld, input bit we,
                        input bit ux);
        int exp_wr;
        @(negedge clk);
        rst = r; pm_rd_word = word[23:0]; pm_data_rd = drd; pm_fetch = fch;
        pm_y_route = yr; reg_src = src[15:0]; xr_load = ld; pm_wr_en = we;
        wr_uses_xr = ux;
        #1;
        check("R2", int'(rd_to_reg), (drd && !fch) ? ((word >> 8) & 16'hFFFF) : 0);
        check("R5", int'(y_operand), yr ? ((word >> 8) & 16'hFFFF) : 0);
        check("R9/R11", int'(xr_read_val), model_xr);
        exp_wr = we ? (((src & 16'hFFFF) << 8) | (ux ? model_xr : 0)) : 0;
        check(ux ? "R6" : "R7", int'(pm_wr_word), exp_wr);
        @(posedge clk);
        if (r) model_xr = 0;                               // R1
        else if (drd && !fch && !yr) model_xr = word & 8'hFF; // R3, R4, R5, R10
        else if (ld) model_xr = src & 8'hFF;               // R8
    endtask

    initial begin
        #400000;
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; pm_rd_word = 0; pm_data_rd = 0; pm_fetch = 0; pm_y_route = 0;
        reg_src = 0; xr_load = 0; pm_wr_en = 0; wr_uses_xr = 0;
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 24'hFFFFFF, 1, 0, 0, 16'hFFFF, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R1 reset state
        step(0, 24'h123456, 1, 0, 0, 0, 0, 0, 0);        // R2 R3 data read
        step(0, 0, 0, 0, 0, 16'hABCD, 0, 1, 1);          // R6 merge 0x56
        step(0, 0, 0, 0, 0, 16'hABCD, 0, 1, 0);          // R7 low byte zero
        step(0, 24'h9988AA, 1, 1, 0, 0, 0, 0, 0);        // R4 fetch with read
        step(0, 24'h7766BB, 0, 1, 0, 0, 0, 0, 0);        // R4 plain fetch
        step(0, 24'hCAFE11, 1, 0, 1, 0, 0, 0, 0);        // R5 Y route
        step(0, 0, 0, 0, 0, 16'hA5C3, 1, 0, 0);          // R8 explicit load
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R9 read back 0x00C3
        step(0, 24'h0000EE, 1, 0, 0, 16'h1177, 1, 1, 1); // R10 R11 collision
        step(0, 0, 0, 0, 0, 16'h2222, 0, 1, 1);          // R10 EE expected
        step(0, 0, 0, 0, 0, 16'h0000, 0, 0, 1);          // R7 no write -> 0
        for (int i = 0; i < 3000; i++) begin
            int w;
            int s;
            bit [7:0] c;
            w = int'($urandom() & 24'hFFFFFF);
            s = int'($urandom() & 16'hFFFF);
            c = 8'($urandom());
            step((i % 500) == 499, w, c[0], c[1] & c[2], c[3] & c[4], s, c[5], c[6], c[7]);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule